// File: doc/BRIEF.md
# Wrap-Safe Credit Tracker

This unit sits on the sending side of a message channel. It decides when the local producer may push one more message into a receive queue on a remote node. The queue has a fixed number of buffers. The unit keeps a free-running count of the messages it has sent. The receiver returns a free-running count of the messages it has consumed. The number of free remote buffers is the queue depth minus the unsigned, modulo-2^N gap between these two counts. This result stays correct when either counter wraps, as long as the counter range is larger than the queue depth.

The receiver's count arrives as a plain 64-bit network word with a valid strobe and no separate notification flag. Internally the unit takes a snapshot of the latest count and evaluates it. If the snapshot shows space, the unit raises a single send permit. When the producer strobes a send, the permit is consumed and a fresh snapshot must be taken before another send is allowed. Each read of the count therefore authorises at most one message. A sample taken while the count is being rewritten can only understate the free space, so it can never cause the queue to overrun. While no space is shown, the unit keeps re-reading the count on its own.

Top module: `credit_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `send_permit` is 0, `sent_count` is 0 and `free_count` is 0.
- R2: On a cycle with `ack_valid` high, the acknowledge count is taken from bits [CNT_W-1:0] of `ack_word`. All higher bits of the word are ignored. No other flag is needed.
- R3: The free space computed from a snapshot is DEPTH - ((sent - ack) mod 2^CNT_W). If that gap exceeds DEPTH, including the case where the acknowledge count is ahead of the sent count, the free space is 0. `free_count` shows the value from the latest evaluation, reduced by one after an accepted send.
- R4: The free-space result stays correct across any number of wraps of either counter.
- R5: `send_permit` is high only when the snapshot it was granted on shows at least one free buffer. Without new acknowledges, the number of outstanding messages never reaches DEPTH plus one.
- R6: A send is accepted when `send_strobe` is high while `send_permit` is high. In the cycle after an accepted send, `send_permit` is 0. It stays 0 for at least one further cycle while a new snapshot is taken and evaluated.
- R7: `sent_count` increments by exactly one, modulo 2^CNT_W, for each accepted send. A strobe while `send_permit` is 0 leaves `sent_count` unchanged.
- R8: When the snapshot shows no space, the unit re-samples the acknowledge count every two cycles. After an acknowledge update that frees space, `send_permit` rises within four cycles.
- R9: Elaboration fails if 2^CNT_W is not greater than DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Acknowledge word present this cycle |
| ack_word | input | WORD_W | Network word; low CNT_W bits carry the receiver's consumed count |
| send_strobe | input | 1 | Producer sends one message this cycle |
| send_permit | output | 1 | One message may be sent |
| sent_count | output | CNT_W | Free-running count of accepted sends |
| free_count | output | $clog2(DEPTH+1) | Free buffers from the latest snapshot |

## Verification
Several properties are checked on every cycle. The permit is only ever held on a snapshot whose gap is below the depth. An accepted send drops the permit and is followed by a dead cycle. The sent counter moves by exactly one per accepted send and holds otherwise. Every acknowledge word is captured from its low field. Other behaviour can only be shown by the bench's scenarios. These cover the numeric free-space values, and the refusal to grant on an acknowledge count that runs ahead of the sent count. They also cover the bounded latency from a freeing acknowledge to a new permit, and safety across many counter wraps under random traffic.

// File: rtl/credit_pkg.sv
package credit_pkg;

    localparam int unsigned NET_WORD_W = 64;

    typedef enum logic [1:0] {
        PH_POLL = 2'd0,
        PH_EVAL = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   permit;
    } sampler_state_t;

    // Unsigned gap between two counters of width w (w <= 32), wrap safe.
    function automatic logic [31:0] ring_gap(input logic [31:0] ahead,
                                             input logic [31:0] behind,
                                             input int unsigned w);
        logic [31:0] mask;
        mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        return (ahead - behind) & mask;
    endfunction

    // Free buffers left for a given gap; a gap beyond depth means no room.
    function automatic logic [31:0] room_left(input logic [31:0] gap,
                                              input logic [31:0] depth);
        return (gap >= depth) ? 32'd0 : (depth - gap);
    endfunction

endpackage

// File: rtl/credit_ack_capture.sv
module credit_ack_capture #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_valid,
    input  logic [WORD_W-1:0] ack_word,
    output logic [CNT_W-1:0]  ack_cnt
);
    logic [CNT_W-1:0] field;
    assign field = ack_word[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)            ack_cnt <= '0;
        else if (ack_valid) ack_cnt <= field;
    end

    AST_ACK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> ack_cnt == $past(ack_word[CNT_W-1:0]))
        else $error("ack capture"); // R2

endmodule

// File: rtl/credit_sent_counter.sv
module credit_sent_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             send_strobe,
    input  logic             send_permit,
    output logic [CNT_W-1:0] sent_cnt
);
    logic accept;
    assign accept = send_strobe & send_permit;

    always_ff @(posedge clk) begin
        if (rst)         sent_cnt <= '0;
        else if (accept) sent_cnt <= sent_cnt + 1'b1;
    end

    AST_SENT_STEP: assert property (@(posedge clk) disable iff (rst)
        (send_strobe && send_permit) |=> sent_cnt == $past(sent_cnt) + 1'b1)
        else $error("sent step"); // R7
    AST_SENT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(send_strobe && send_permit) |=> $stable(sent_cnt))
        else $error("sent hold"); // R7

endmodule

// File: rtl/credit_sampler.sv
module credit_sampler
    import credit_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned FREE_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  ack_cnt,
    input  logic [CNT_W-1:0]  sent_cnt,
    input  logic              send_strobe,
    output logic              send_permit,
    output logic [FREE_W-1:0] free_count
);
    sampler_state_t   st;
    logic [CNT_W-1:0] snap;
    logic [31:0]      gap;
    logic [31:0]      room;
    logic [FREE_W-1:0] room_w;

    always_comb begin
        gap    = ring_gap(32'(sent_cnt), 32'(snap), CNT_W);
        room   = room_left(gap, 32'(DEPTH));
        room_w = FREE_W'(room);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase   <= PH_POLL;
            st.permit  <= 1'b0;
            snap       <= '0;
            free_count <= '0;
        end else begin
            case (st.phase)
                PH_POLL: begin
                    snap     <= ack_cnt;
                    st.phase <= PH_EVAL;
                end
                PH_EVAL: begin
                    free_count <= room_w;
                    if (room != 32'd0) begin
                        st.permit <= 1'b1;
                        st.phase  <= PH_HOLD;
                    end else begin
                        st.phase  <= PH_POLL;
                    end
                end
                PH_HOLD: begin
                    if (send_strobe) begin
                        st.permit  <= 1'b0;
                        free_count <= free_count - 1'b1;
                        st.phase   <= PH_POLL;
                    end
                end
                default: begin
                    st.permit <= 1'b0;
                    st.phase  <= PH_POLL;
                end
            endcase
        end
    end

    assign send_permit = st.permit;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        send_permit |-> ring_gap(32'(sent_cnt), 32'(snap), CNT_W) < 32'(DEPTH))
        else $error("permit without room"); // R5
    AST_DROP_AFTER_SEND: assert property (@(posedge clk) disable iff (rst)
        (send_strobe && send_permit) |=> !send_permit)
        else $error("permit not consumed"); // R6
    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (rst)
        $fell(send_permit) |=> !send_permit)
        else $error("regrant without sample"); // R6

endmodule

// File: rtl/credit_tracker.sv
module credit_tracker
    import credit_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned WORD_W = NET_WORD_W,
    localparam int unsigned FREE_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_valid,
    input  logic [WORD_W-1:0] ack_word,
    input  logic              send_strobe,
    output logic              send_permit,
    output logic [CNT_W-1:0]  sent_count,
    output logic [FREE_W-1:0] free_count
);
    // R9: the counter range must exceed the queue depth.
    if (CNT_W > 32 || CNT_W > WORD_W || CNT_W == 0) begin : g_bad_width
        $error("counter width out of range");
    end else if ((64'd1 << CNT_W) <= 64'(DEPTH)) begin : g_bad_range_r9
        $error("counter range must exceed queue depth");
    end

    logic [CNT_W-1:0] ack_cnt;

    credit_ack_capture #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_ack (
        .clk(clk), .rst(rst), .ack_valid(ack_valid),
        .ack_word(ack_word), .ack_cnt(ack_cnt)
    );

    credit_sent_counter #(.CNT_W(CNT_W)) u_sent (
        .clk(clk), .rst(rst), .send_strobe(send_strobe),
        .send_permit(send_permit), .sent_cnt(sent_count)
    );

    credit_sampler #(.CNT_W(CNT_W), .DEPTH(DEPTH), .FREE_W(FREE_W)) u_samp (
        .clk(clk), .rst(rst), .ack_cnt(ack_cnt), .sent_cnt(sent_count),
        .send_strobe(send_strobe), .send_permit(send_permit),
        .free_count(free_count)
    );

endmodule

// File: tb/credit_tracker_tb.sv
module credit_tracker_tb;
    localparam int unsigned CW = 4;
    localparam int unsigned DP = 4;
    localparam int unsigned WW = 64;
    localparam int unsigned FW = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ack_valid = 1'b0;
    logic [WW-1:0] ack_word = '0;
    logic          send_strobe = 1'b0;
    logic          send_permit;
    logic [CW-1:0] sent_count;
    logic [FW-1:0] free_count;

    int checks = 0;
    int fails  = 0;
    int sent_m = 0;
    int ack_m  = 0;

    always #4 clk = ~clk;

    credit_tracker #(.CNT_W(CW), .DEPTH(DP), .WORD_W(WW)) u_dut (
        .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_word(ack_word),
        .send_strobe(send_strobe), .send_permit(send_permit),
        .sent_count(sent_count), .free_count(free_count)
    );

    function automatic int outstanding(int s, int a);
        return (s - a) & ((1 << CW) - 1);
    endfunction

    function automatic int exp_room(int s, int a);
        int g;
        g = outstanding(s, a);
        return (g >= DP) ? 0 : DP - g;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push_ack(int val);
        ack_m     = val & ((1 << CW) - 1);
        ack_valid = 1'b1;
        ack_word  = {$urandom, $urandom};
        ack_word[CW-1:0] = CW'(ack_m);
        tick();
        ack_valid = 1'b0;
    endtask

    task automatic wait_permit(int max, output bit got);
        got = 1'b0;
        for (int i = 0; i < max && !got; i++) begin
            if (send_permit) got = 1'b1;
            else tick();
        end
    endtask

    task automatic send_one();
        bit got;
        wait_permit(8, got);
        chk(got, "R5 permit expected", int'(send_permit), 1);
        if (got) begin
            send_strobe = 1'b1;
            sent_m++;
            tick();
            send_strobe = 1'b0;
            chk(send_permit == 1'b0, "R6 drop after send", int'(send_permit), 0);
            chk(int'(sent_count) == (sent_m & ((1 << CW) - 1)), "R7 count step",
                int'(sent_count), sent_m & ((1 << CW) - 1));
            tick();
            chk(send_permit == 1'b0, "R6 dead cycle", int'(send_permit), 0);
        end
    endtask

    initial begin
        bit got;
        int nsend;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk(send_permit == 1'b0, "R1 permit", int'(send_permit), 0);
        chk(sent_count == '0, "R1 sent", int'(sent_count), 0);
        chk(free_count == '0, "R1 free", int'(free_count), 0);
        tick(); tick();
        chk(send_permit == 1'b1, "R5 first grant", int'(send_permit), 1);
        chk(int'(free_count) == DP, "R3 empty queue room", int'(free_count), DP);

        // Fill the queue with no acknowledges
        for (int k = 0; k < DP; k++) send_one();
        for (int k = 0; k < 10; k++) begin
            tick();
            chk(send_permit == 1'b0, "R5 full queue", int'(send_permit), 0);
        end
        chk(free_count == '0, "R3 full room", int'(free_count), 0);

        // Strobes while permit low are ignored
        send_strobe = 1'b1;
        repeat (3) tick();
        send_strobe = 1'b0;
        chk(int'(sent_count) == DP, "R7 ignored strobe", int'(sent_count), DP);

        // Ack with noisy upper bits frees two buffers
        push_ack(2);
        wait_permit(4, got);
        chk(got, "R8 permit after ack", int'(send_permit), 1);
        chk(int'(free_count) == exp_room(sent_m, ack_m), "R2 R3 low field room",
            int'(free_count), exp_room(sent_m, ack_m));

        send_one(); send_one();
        // Acknowledge count ahead of sent: no room
        push_ack(sent_m + 5);
        for (int k = 0; k < 10; k++) begin
            tick();
            chk(send_permit == 1'b0, "R3 ack ahead", int'(send_permit), 0);
        end
        push_ack(sent_m);
        wait_permit(4, got);
        chk(got, "R8 recover", int'(send_permit), 1);
        chk(int'(free_count) == DP, "R3 recovered room", int'(free_count), DP);

        // Random traffic across many counter wraps
        nsend = 0;
        for (int c = 0; c < 3000; c++) begin
            if (send_permit)
                chk(outstanding(sent_m, ack_m) < DP, "R4 R5 wrap safe",
                    outstanding(sent_m, ack_m), DP - 1);
            chk(int'(sent_count) == (sent_m & ((1 << CW) - 1)), "R7 random count",
                int'(sent_count), sent_m & ((1 << CW) - 1));
            send_strobe = ($urandom % 2) == 1;
            if (send_strobe && send_permit) begin
                sent_m++;
                nsend++;
            end
            if (($urandom % 4) == 0 && outstanding(sent_m, ack_m) != 0) begin
                ack_m = ack_m + 1 + int'($urandom % outstanding(sent_m, ack_m));
                ack_m = ack_m & ((1 << CW) - 1);
                ack_valid = 1'b1;
                ack_word  = {$urandom, $urandom};
                ack_word[CW-1:0] = CW'(ack_m);
            end else begin
                ack_valid = 1'b0;
            end
            tick();
        end
        send_strobe = 1'b0;
        ack_valid   = 1'b0;
        chk(nsend > 200, "R8 R4 progress", nsend, 201);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule